// File: doc/BRIEF.md
# ADC Conversion Sequencer and Status Register

This block is the digital control side of a successive-approximation converter. Software sees one 8-bit control/status byte holding a conversion-done flag, an interrupt enable, a repeat (continuous) enable and a 5-bit channel code. The block decides when a conversion begins: on a write to that byte in software-trigger mode, or on a rising edge of a trigger input in hardware-trigger mode. It runs either one conversion or an unbroken chain of them. It then qualifies the done flag with an optional compare verdict, clears the flag, and drives an interrupt request and a power-down indication.

The analog converter is modelled by a behavioural stub that takes a fixed number of clock cycles per conversion. Its result word carries the sampled channel code in the upper five bits and, in the remaining lower bits, a running count of completed conversions. This makes every completion visible at the result port. A channel code of all ones shuts the converter off and ends a repeating chain cleanly.

Top module: `adcc_top`

## Requirements
- R1: After reset the control byte reads 0x1F (flag, interrupt enable and repeat enable clear, channel 11111), `irq` is low, `pwr_down` is high and `result` is zero.
- R2: The done flag (bit 7) is read-only. A write stores bits 6:0 only (bit 6 interrupt enable, bit 5 repeat enable, bits 4:0 channel) and never sets bit 7.
- R3: In software mode (`hw_trig_sel`=0) with repeat off, a write with channel other than 11111 starts exactly one conversion. The flag and the new result appear CONV_CYCLES clock edges after the write edge, and `pwr_down` returns high in that same cycle.
- R4: In software mode with repeat on, a write starts conversions back to back, one result every CONV_CYCLES edges, and `pwr_down` stays low throughout.
- R5: In hardware mode a write only updates the fields and starts nothing. Each rising edge of `hw_trig` seen while the converter is idle starts one conversion. Edges seen while a conversion is running are ignored.
- R6: In hardware mode with repeat on, one trigger edge starts a back-to-back chain.
- R7: Writing channel 11111 stops any conversion at the next edge. No further result follows, and `pwr_down` is high from that edge.
- R8: With `cmp_en`=1 the flag sets on a completion only if `cmp_true` is high in the completing cycle. The result updates on every completion regardless.
- R9: The flag clears on any write and on a `rd_lo` strobe. A completion in the same cycle as a clearing event leaves the flag set.
- R10: `irq` is high exactly when the flag and the interrupt enable (bit 6) are both set.
- R11: A write during a running conversion aborts it. The aborted conversion produces no result and no flag, and the new conversion's timing counts from the new write edge.
- R12: Each result equals {channel code, count of completions since reset modulo 2^(RES_W-5)}. All channel codes below 11111 convert, including 11100 to 11110.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Write data for the control byte |
| rd_lo | input | 1 | Strobe marking a read of the low result byte |
| hw_trig_sel | input | 1 | 1 selects hardware triggering, 0 software triggering |
| hw_trig | input | 1 | Hardware trigger; its rising edge counts |
| cmp_en | input | 1 | Enables compare qualification of the done flag |
| cmp_true | input | 1 | Compare verdict for the completing conversion |
| ctrl_q | output | 8 | Control byte read value |
| result | output | RES_W | Latest conversion result |
| conv_chan | output | 5 | Channel held by the converter for the current conversion |
| irq | output | 1 | Conversion-done interrupt request |
| pwr_down | output | 1 | High while the converter is idle and powered down |

## Verification
A single software conversion is compared against a repeating chain and against a chain stopped by the off code. This separates the single-shot stop from the repeat path and from a leaked extra conversion. Hardware triggers are applied while idle, while busy, and alongside writes. These show that writes start nothing in that mode, that busy-time edges are dropped, and that one edge can launch a chain. Two rewrites mid-conversion test the abort timing. A clear strobe placed on the exact completing edge exposes the set-over-clear priority. Compare-enabled runs with the verdict low and then high show that the result advances even while the flag is suppressed.

// File: rtl/adcc_pkg.sv
package adcc_pkg;

    localparam int CHAN_W = 5;
    localparam logic [CHAN_W-1:0] CHAN_OFF = '1;

    typedef logic [CHAN_W-1:0] chan_t;

    typedef struct packed {
        logic  done_flag;
        logic  irq_en;
        logic  repeat_en;
        chan_t chan;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{done_flag: 1'b0, irq_en: 1'b0,
                                     repeat_en: 1'b0, chan: CHAN_OFF};

    function automatic logic chan_is_off(input chan_t c);
        return c == CHAN_OFF;
    endfunction

endpackage

// File: rtl/adcc_ctrl_reg.sv
module adcc_ctrl_reg
    import adcc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  ctrl_t wr_fields,
    input  logic  rd_lo,
    input  logic  conv_done,
    input  logic  cmp_en,
    input  logic  cmp_true,
    output ctrl_t ctrl
);
    logic flag_set;
    logic flag_clr;

    assign flag_set = conv_done && (!cmp_en || cmp_true);
    assign flag_clr = wr_en || rd_lo;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= CTRL_RESET;
        end else begin
            if (wr_en) begin
                ctrl.irq_en    <= wr_fields.irq_en;
                ctrl.repeat_en <= wr_fields.repeat_en;
                ctrl.chan      <= wr_fields.chan;
            end
            if (flag_set)
                ctrl.done_flag <= 1'b1;
            else if (flag_clr)
                ctrl.done_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/adcc_seq.sv
module adcc_seq
    import adcc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  ctrl_t wr_fields,
    input  ctrl_t ctrl,
    input  logic  hw_trig_sel,
    input  logic  hw_trig,
    input  logic  busy,
    input  logic  done,
    output logic  start,
    output logic  stop,
    output chan_t start_chan
);
    logic trig_q;
    logic trig_rise;

    always_ff @(posedge clk) begin
        if (rst) trig_q <= 1'b0;
        else     trig_q <= hw_trig;
    end

    assign trig_rise = hw_trig && !trig_q;

    always_comb begin
        start      = 1'b0;
        stop       = 1'b0;
        start_chan = ctrl.chan;
        if (wr_en) begin
            if (!hw_trig_sel && !chan_is_off(wr_fields.chan)) begin
                start      = 1'b1;
                start_chan = wr_fields.chan;
            end else begin
                stop = 1'b1;
            end
        end else if (done && ctrl.repeat_en && !chan_is_off(ctrl.chan)) begin
            start = 1'b1;
        end else if (hw_trig_sel && trig_rise && !busy && !chan_is_off(ctrl.chan)) begin
            start = 1'b1;
        end
    end
endmodule

// File: rtl/adcc_sar_stub.sv
module adcc_sar_stub
    import adcc_pkg::*;
#(
    parameter int CONV_CYCLES = 8,
    parameter int RES_W       = 12
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             stop,
    input  chan_t            chan_in,
    output logic             busy,
    output logic             done,
    output chan_t            chan_held,
    output logic [RES_W-1:0] data
);
    localparam int TICK_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
    localparam int SEQ_W  = RES_W - CHAN_W;

    logic [TICK_W-1:0] tick_q;
    logic [SEQ_W-1:0]  seq_q;
    logic [SEQ_W-1:0]  seq_next;

    assign done     = busy && (tick_q == '0);
    assign seq_next = seq_q + SEQ_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            tick_q    <= '0;
            chan_held <= CHAN_OFF;
            seq_q     <= '0;
            data      <= '0;
        end else begin
            if (start) begin
                busy      <= 1'b1;
                tick_q    <= TICK_W'(CONV_CYCLES - 1);
                chan_held <= chan_in;
            end else if (stop || done) begin
                busy <= 1'b0;
            end else if (busy) begin
                tick_q <= tick_q - TICK_W'(1);
            end
            if (done) begin
                seq_q <= seq_next;
                data  <= {chan_held, seq_next};
            end
        end
    end
endmodule

// File: rtl/adcc_top.sv
module adcc_top
    import adcc_pkg::*;
#(
    parameter int CONV_CYCLES = 8,
    parameter int RES_W       = 12
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic             rd_lo,
    input  logic             hw_trig_sel,
    input  logic             hw_trig,
    input  logic             cmp_en,
    input  logic             cmp_true,
    output logic [7:0]       ctrl_q,
    output logic [RES_W-1:0] result,
    output logic [4:0]       conv_chan,
    output logic             irq,
    output logic             pwr_down
);
    ctrl_t wr_fields;
    ctrl_t ctrl;
    logic  conv_start;
    logic  conv_stop;
    logic  conv_busy;
    logic  conv_done;
    chan_t start_chan;

    assign wr_fields = ctrl_t'(wr_data);

    adcc_ctrl_reg u_reg (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_fields (wr_fields),
        .rd_lo     (rd_lo),
        .conv_done (conv_done),
        .cmp_en    (cmp_en),
        .cmp_true  (cmp_true),
        .ctrl      (ctrl)
    );

    adcc_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_fields   (wr_fields),
        .ctrl        (ctrl),
        .hw_trig_sel (hw_trig_sel),
        .hw_trig     (hw_trig),
        .busy        (conv_busy),
        .done        (conv_done),
        .start       (conv_start),
        .stop        (conv_stop),
        .start_chan  (start_chan)
    );

    adcc_sar_stub #(.CONV_CYCLES(CONV_CYCLES), .RES_W(RES_W)) u_sar (
        .clk       (clk),
        .rst       (rst),
        .start     (conv_start),
        .stop      (conv_stop),
        .chan_in   (start_chan),
        .busy      (conv_busy),
        .done      (conv_done),
        .chan_held (conv_chan),
        .data      (result)
    );

    assign ctrl_q   = ctrl;
    assign irq      = ctrl.done_flag && ctrl.irq_en;
    assign pwr_down = !conv_busy;
endmodule

// File: rtl/adcc_checker.sv
module adcc_checker #(
    parameter int RES_W = 12
)(
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [7:0]       wr_data,
    input logic             rd_lo,
    input logic             hw_trig_sel,
    input logic [7:0]       ctrl_q,
    input logic [RES_W-1:0] result,
    input logic             irq,
    input logic             pwr_down,
    input logic             conv_done
);
    // R8: the flag only rises right after a completion
    p_flag_src_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl_q[7]) |-> $past(conv_done));

    // R9: a read strobe with no completion clears the flag
    p_rd_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_lo && !conv_done) |=> !ctrl_q[7]);

    // R12: result moves only on a completion
    p_res_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !conv_done |=> $stable(result));

    // R5: a write in hardware mode leaves the converter idle
    p_hw_wr_idle_r5: assert property (@(posedge clk) disable iff (rst)
        (hw_trig_sel && wr_en) |=> pwr_down);

    // R7: the off code powers down at the next edge
    p_off_code_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[4:0] == 5'h1F) |=> pwr_down);

    // R10: no request while the enable is clear
    p_irq_gate_r10: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q[6] |-> !irq);

    // R3: single mode idles after its completion
    p_single_idle_r3: assert property (@(posedge clk) disable iff (rst)
        (conv_done && !ctrl_q[5] && !wr_en) |=> pwr_down);
endmodule

bind adcc_top adcc_checker #(.RES_W(RES_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .rd_lo       (rd_lo),
    .hw_trig_sel (hw_trig_sel),
    .ctrl_q      (ctrl_q),
    .result      (result),
    .irq         (irq),
    .pwr_down    (pwr_down),
    .conv_done   (conv_done)
);

// File: tb/adcc_top_tb.sv
module adcc_top_tb;
    localparam int C     = 8;
    localparam int RES_W = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic rd_lo = 1'b0;
    logic hw_trig_sel = 1'b0;
    logic hw_trig = 1'b0;
    logic cmp_en = 1'b0;
    logic cmp_true = 1'b0;
    logic [7:0] ctrl_q;
    logic [RES_W-1:0] result;
    logic [4:0] conv_chan;
    logic irq;
    logic pwr_down;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int last_edge = 0;
    int conv_count = 0;
    bit done_flag = 0;

    typedef struct {
        logic [RES_W-1:0] value;
        int               edge_no;
    } item_t;
    item_t sb_q[$];
    logic [RES_W-1:0] prev_result = '0;

    always #2 clk = ~clk;

    adcc_top #(.CONV_CYCLES(C), .RES_W(RES_W)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_lo(rd_lo),
        .hw_trig_sel(hw_trig_sel), .hw_trig(hw_trig), .cmp_en(cmp_en),
        .cmp_true(cmp_true), .ctrl_q(ctrl_q), .result(result),
        .conv_chan(conv_chan), .irq(irq), .pwr_down(pwr_down)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1;
        wr_data = d;
        @(posedge clk);
        #1;
        last_edge = cyc;
        wr_en = 1'b0;
    endtask

    task automatic trig();
        hw_trig = 1'b1;
        @(posedge clk);
        #1;
        last_edge = cyc;
        hw_trig = 1'b0;
    endtask

    // driver side of the scoreboard: R12 value model
    task automatic expect_conv(input logic [4:0] ch, input int edge_no);
        item_t it;
        conv_count++;
        it.value = {ch, 7'(conv_count)};
        it.edge_no = edge_no;
        sb_q.push_back(it);
    endtask

    // monitor side of the scoreboard
    always @(negedge clk) begin
        if (!rst && result != prev_result) begin
            if (sb_q.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL R3/R7/R11: unexpected result 0x%0h at edge %0d expected none",
                         result, cyc);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                check("R12 result value", int'(result), int'(it.value));
                check("R3/R4 completion edge", cyc, it.edge_no);
            end
        end
        prev_result = result;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        // R1 reset state
        check("R1 ctrl", ctrl_q, 8'h1F);
        check("R1 irq", irq, 0);
        check("R1 pwr_down", pwr_down, 1);
        check("R1 result", result, 0);

        // R2 / R3 single software conversion, bit 7 write ignored
        wr(8'hC3);
        check("R2 ro flag", ctrl_q, 8'h43);
        check("R3 running", pwr_down, 0);
        expect_conv(5'h03, last_edge + C);
        tick(C - 1);
        check("R3 not early", ctrl_q[7], 0);
        tick(1);
        check("R3 flag", ctrl_q, 8'hC3);
        check("R10 irq on", irq, 1);
        check("R3 idle", pwr_down, 1);
        tick(20);
        // R9 clear by low-byte read
        rd_lo = 1'b1;
        tick(1);
        rd_lo = 1'b0;
        check("R9 rd clear", ctrl_q, 8'h43);
        check("R10 irq off", irq, 0);

        // R9 set wins over simultaneous read
        wr(8'h07);
        expect_conv(5'h07, last_edge + C);
        tick(C - 1);
        rd_lo = 1'b1;
        tick(1);
        rd_lo = 1'b0;
        check("R9 set wins", ctrl_q[7], 1);
        check("R10 irq gated", irq, 0);
        // R9 clear by write, R7 off code
        wr(8'h1F);
        check("R9 wr clear", ctrl_q, 8'h1F);
        check("R7 off idle", pwr_down, 1);

        // R4 software repeat, then R7 stop
        wr(8'h22);
        expect_conv(5'h02, last_edge + C);
        expect_conv(5'h02, last_edge + 2 * C);
        expect_conv(5'h02, last_edge + 3 * C);
        tick(12);
        check("R4 busy", pwr_down, 0);
        tick(15);
        check("R4 busy late", pwr_down, 0);
        wr(8'h3F);
        check("R7 stop", pwr_down, 1);
        check("R7 ctrl", ctrl_q, 8'h3F);
        tick(20);
        check("R7 stays off", pwr_down, 1);

        // R11 abort by rewrite
        wr(8'h04);
        tick(3);
        wr(8'h06);
        expect_conv(5'h06, last_edge + C);
        tick(C - 1);
        check("R11 no flag yet", ctrl_q[7], 0);
        tick(1);
        check("R11 flag", ctrl_q[7], 1);
        check("R11 channel", conv_chan, 5'h06);
        tick(5);

        // R5 hardware single
        hw_trig_sel = 1'b1;
        wr(8'h09);
        tick(12);
        check("R5 no start", pwr_down, 1);
        check("R5 fields", ctrl_q, 8'h09);
        trig();
        expect_conv(5'h09, last_edge + C);
        tick(2);
        trig();
        tick(10);
        check("R5 flag", ctrl_q[7], 1);
        check("R5 idle", pwr_down, 1);
        trig();
        expect_conv(5'h09, last_edge + C);
        tick(12);

        // R6 hardware repeat
        wr(8'h2A);
        tick(5);
        check("R6 no start", pwr_down, 1);
        trig();
        expect_conv(5'h0A, last_edge + C);
        expect_conv(5'h0A, last_edge + 2 * C);
        tick(10);
        check("R6 busy", pwr_down, 0);
        tick(9);
        wr(8'h3F);
        check("R7 hw stop", pwr_down, 1);
        tick(20);
        hw_trig_sel = 1'b0;

        // R8 compare qualification
        cmp_en = 1'b1;
        cmp_true = 1'b0;
        wr(8'h45);
        expect_conv(5'h05, last_edge + C);
        tick(C + 1);
        check("R8 suppressed", ctrl_q[7], 0);
        check("R8 irq low", irq, 0);
        cmp_true = 1'b1;
        wr(8'h45);
        expect_conv(5'h05, last_edge + C);
        tick(C + 1);
        check("R8 set", ctrl_q[7], 1);
        check("R10 irq cmp", irq, 1);
        cmp_en = 1'b0;
        cmp_true = 1'b0;

        // R10 enable off, R12 reference codes
        wr(8'h01);
        expect_conv(5'h01, last_edge + C);
        tick(C + 1);
        check("R10 en off", irq, 0);
        wr(8'h1D);
        expect_conv(5'h1D, last_edge + C);
        tick(C + 1);
        check("R12 ref code", ctrl_q, 8'h9D);
        wr(8'h1C);
        expect_conv(5'h1C, last_edge + C);
        tick(C + 1);
        check("R12 reserved code", ctrl_q, 8'h9C);

        tick(5);
        check("R3 queue drained", sb_q.size(), 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule